// File: doc/BRIEF.md
# Duplicate-Tag Snoop Filter

This block sits beside a direct-mapped cache and holds its own copy of that cache's tag store: one tag and one valid bit per set. The cache controller reports every tag write it makes, either a fill that sets an entry or a clear that drops one. The filter applies the same write to its copy on the same clock edge.

Line addresses observed on the shared bus are compared only against this copy. A snoop that misses is absorbed here and the cache is never touched. A snoop that hits raises an invalidate request carrying the set index toward the cache. The matching entry in the copy is cleared at the same time. The request stays up until the cache acknowledges it, and no new snoop is accepted while it is pending.

Top module: `snoop_filter`

## Requirements
- R1: After reset, invReq is low and snpReady is high, and every entry is invalid, so no snoop raises an invalidate until an entry has been filled.
- R2: After an update with updSetValid=1 writes tag T at index I, a snoop of line {T, I} (index in the low IDX_W bits, tag above it) raises invReq on the clock edge that accepts it, with invIndex equal to I.
- R3: A snoop whose tag differs from the stored tag, or whose set holds no valid entry, leaves invReq low.
- R4: An update with updSetValid=0 invalidates the entry at its index, so a later snoop of the old line raises no invalidate.
- R5: While invReq is high and invAck is low, invReq stays high and invIndex keeps its value.
- R6: While invReq is high, snpReady is low, and a snoop presented then has no effect: it neither raises an invalidate nor clears any entry.
- R7: A snoop hit clears the matching entry, so repeating the same snoop raises no invalidate.
- R8: When an update and an accepted snoop name the same set in one cycle, the snoop is compared against the newly written tag, and on a hit the entry ends invalid.
- R9: The edge that samples invAck high with invReq high drops invReq, and snpReady is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | Cache tag write this cycle |
| updSetValid | input | 1 | 1 fills the entry, 0 clears it |
| updIndex | input | IDX_W | Set written |
| updTag | input | TAG_W | Tag written |
| snpValid | input | 1 | Bus snoop presented |
| snpLine | input | TAG_W+IDX_W | Snooped line address {tag, index} |
| snpReady | output | 1 | Snoop accepted this cycle when high |
| invReq | output | 1 | Invalidate request to the cache |
| invIndex | output | IDX_W | Set to invalidate |
| invAck | input | 1 | Cache has performed the invalidate |

## Verification
The bench presents an update and a snoop to the same set in the same cycle. A design that looks up the old tag misses the new line, or it hits the stale one. A design that lets the fill win over the clear leaves the entry live after a hit. The bench also holds back the acknowledge for several cycles and presents a matching snoop to another set during the stall. A design that does not stall either loses the first request or silently clears the second entry, and a later snoop of that set then fails to hit. Snoops are also repeated after a hit and after a controller clear, which catches a copy that is never cleared.

// File: rtl/snoop_filter_pkg.sv
package snoop_filter_pkg;
  // strobes from the control to the tag datapath
  typedef struct packed {
    logic lookupEn;  // snoop accepted this cycle
    logic clearEn;   // accepted snoop hit: clear entry, capture index
  } filterStrobes_t;
endpackage

// File: rtl/snoop_filter_tags.sv
module snoop_filter_tags
  import snoop_filter_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     updValid,
  input  logic                     updSetValid,
  input  logic [IDX_W-1:0]         updIndex,
  input  logic [TAG_W-1:0]         updTag,
  input  logic [TAG_W+IDX_W-1:0]   snpLine,
  input  filterStrobes_t           strobes,
  output logic                     tagMatch,
  output logic [IDX_W-1:0]         invIndex
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int LINE_W = TAG_W + IDX_W;

  logic [DEPTH-1:0] validQ;
  logic [TAG_W-1:0] tagQ [DEPTH];

  logic [IDX_W-1:0] snpIdx;
  logic [TAG_W-1:0] snpTag;
  logic             sameSet;
  logic             effValid;
  logic [TAG_W-1:0] effTag;

  assign snpIdx = snpLine[IDX_W-1:0];
  assign snpTag = snpLine[LINE_W-1:IDX_W];

  // a same-cycle update is seen by the snoop before comparison
  always_comb begin
    sameSet  = updValid && (updIndex == snpIdx);
    effValid = sameSet ? updSetValid : validQ[snpIdx];
    effTag   = sameSet ? updTag : tagQ[snpIdx];
    tagMatch = strobes.lookupEn && effValid && (effTag == snpTag);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic updHere;
    logic clrHere;
    assign updHere = updValid && (updIndex == IDX_W'(e));
    assign clrHere = strobes.clearEn && (snpIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
      end else begin
        if (updHere) validQ[e] <= updSetValid;
        if (clrHere) validQ[e] <= 1'b0;  // snoop applied after update
      end
    end

    always_ff @(posedge clk) begin
      if (updHere && updSetValid) tagQ[e] <= updTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               invIndex <= '0;
    else if (strobes.clearEn) invIndex <= snpIdx;
  end
endmodule

// File: rtl/snoop_filter_ctrl.sv
module snoop_filter_ctrl
  import snoop_filter_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           snpValid,
  input  logic           tagMatch,
  input  logic           invAck,
  output logic           snpReady,
  output logic           invReq,
  output filterStrobes_t strobes
);
  logic invReqQ;

  assign snpReady        = !invReqQ;
  assign invReq          = invReqQ;
  assign strobes.lookupEn = snpValid && snpReady;
  assign strobes.clearEn  = tagMatch;

  always_ff @(posedge clk) begin
    if (!rstN)                  invReqQ <= 1'b0;
    else if (invReqQ && invAck) invReqQ <= 1'b0;
    else if (strobes.clearEn)   invReqQ <= 1'b1;
  end
endmodule

// File: rtl/snoop_filter.sv
module snoop_filter
  import snoop_filter_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   updValid,
  input  logic                   updSetValid,
  input  logic [IDX_W-1:0]       updIndex,
  input  logic [TAG_W-1:0]       updTag,
  input  logic                   snpValid,
  input  logic [TAG_W+IDX_W-1:0] snpLine,
  output logic                   snpReady,
  output logic                   invReq,
  output logic [IDX_W-1:0]       invIndex,
  input  logic                   invAck
);
  filterStrobes_t strobes;
  logic           tagMatch;

  snoop_filter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .snpValid(snpValid), .tagMatch(tagMatch),
    .invAck(invAck), .snpReady(snpReady), .invReq(invReq), .strobes(strobes)
  );

  snoop_filter_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updSetValid(updSetValid),
    .updIndex(updIndex), .updTag(updTag), .snpLine(snpLine),
    .strobes(strobes), .tagMatch(tagMatch), .invIndex(invIndex)
  );
endmodule

// File: rtl/snoop_filter_checker.sv
module snoop_filter_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             snpValid,
  input logic             snpReady,
  input logic             invReq,
  input logic             invAck,
  input logic [IDX_W-1:0] invIndex
);
  // R5: request and index held until acknowledged
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    invReq && !invAck |=> invReq && $stable(invIndex));

  // R6: no snoop accepted while an invalidate is pending
  p_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    invReq |-> !snpReady);

  // R9: acknowledge releases the request
  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    invReq && invAck |=> !invReq);

  // R2: a new request only follows an accepted snoop
  p_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(invReq) |-> $past(snpValid && snpReady));

  // R3: nothing accepted, nothing pending -> nothing raised
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(snpValid && snpReady) && !invReq |=> !invReq);
endmodule

bind snoop_filter snoop_filter_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .snpValid(snpValid), .snpReady(snpReady),
  .invReq(invReq), .invAck(invAck), .invIndex(invIndex)
);

// File: tb/snoop_filter_test.sv
module snoop_filter_test;
  localparam int IDX_W = 4;
  localparam int TAG_W = 8;
  localparam int LINE_W = IDX_W + TAG_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic updValid = 1'b0, updSetValid = 1'b0;
  logic [IDX_W-1:0] updIndex = '0;
  logic [TAG_W-1:0] updTag = '0;
  logic snpValid = 1'b0;
  logic [LINE_W-1:0] snpLine = '0;
  logic snpReady, invReq, invAck = 1'b0;
  logic [IDX_W-1:0] invIndex;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  snoop_filter #(.IDX_W(IDX_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updSetValid(updSetValid),
    .updIndex(updIndex), .updTag(updTag), .snpValid(snpValid), .snpLine(snpLine),
    .snpReady(snpReady), .invReq(invReq), .invIndex(invIndex), .invAck(invAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doUpdate(input bit setV, input int idx, input int tag);
    @(negedge clk);
    updValid = 1'b1; updSetValid = setV;
    updIndex = IDX_W'(idx); updTag = TAG_W'(tag);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic ackInv(input string req);
    invAck = 1'b1;
    @(negedge clk);
    invAck = 1'b0;
    check(!invReq && snpReady, req, {invReq, snpReady}, 2'b01);
  endtask

  // one-cycle snoop; result sampled at the next negedge
  task automatic doSnoop(input int idx, input int tag, input bit expInv, input string req);
    @(negedge clk);
    snpValid = 1'b1; snpLine = {TAG_W'(tag), IDX_W'(idx)};
    @(negedge clk);
    snpValid = 1'b0;
    check(invReq == expInv, req, invReq, expInv);
    if (expInv) begin
      check(invIndex == IDX_W'(idx), req, invIndex, idx);
      ackInv("R9");
    end else if (invReq) begin
      ackInv("R9");
    end
  endtask

  // {op[1:0], idx[3:0], tag[7:0], expInv}; op 0 fill, 1 clear, 2 snoop
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 4'd3,  8'hA5, 1'b0},
    {2'd2, 4'd3,  8'hA5, 1'b1},  // R2 hit
    {2'd2, 4'd3,  8'hA5, 1'b0},  // R7 entry cleared by hit
    {2'd0, 4'd3,  8'hA5, 1'b0},
    {2'd2, 4'd3,  8'h5A, 1'b0},  // R3 tag mismatch
    {2'd2, 4'd4,  8'hA5, 1'b0},  // R3 invalid set
    {2'd0, 4'd7,  8'h11, 1'b0},
    {2'd1, 4'd7,  8'h11, 1'b0},
    {2'd2, 4'd7,  8'h11, 1'b0},  // R4 cleared by controller
    {2'd0, 4'd15, 8'hFF, 1'b0},
    {2'd2, 4'd15, 8'hFF, 1'b1},  // R2 top set
    {2'd2, 4'd3,  8'hA5, 1'b1}   // R2 refilled entry
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!invReq && snpReady, "R1", {invReq, snpReady}, 2'b01);
    rstN = 1'b1;
    doSnoop(0, 0, 1'b0, "R1");
    doSnoop(9, 8'h00, 1'b0, "R1");

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op;
      op = VEC[v][14:13];
      if (op == 2'd2)
        doSnoop(int'(VEC[v][12:9]), int'(VEC[v][8:1]), VEC[v][0],
                VEC[v][0] ? "R2" : "R3/R4/R7");
      else
        doUpdate(op == 2'd0, int'(VEC[v][12:9]), int'(VEC[v][8:1]));
    end

    // R5 / R6: held request, stalled snoop to another live set
    doUpdate(1'b1, 2, 8'h40);
    doUpdate(1'b1, 15, 8'hFF);
    @(negedge clk);
    snpValid = 1'b1; snpLine = {8'h40, 4'd2};
    @(negedge clk);
    snpLine = {8'hFF, 4'd15};  // presented while stalled
    for (int k = 0; k < 3; k++) begin
      check(invReq && invIndex == 4'd2, "R5", {invReq, invIndex}, {1'b1, 4'd2});
      check(!snpReady, "R6", snpReady, 0);
      @(negedge clk);
    end
    snpValid = 1'b0;
    ackInv("R9");
    doSnoop(15, 8'hFF, 1'b1, "R6");  // stalled snoop left entry live

    // R8: same-cycle update and snoop to one set
    doUpdate(1'b1, 9, 8'h22);
    @(negedge clk);
    updValid = 1'b1; updSetValid = 1'b1; updIndex = 4'd9; updTag = 8'h33;
    snpValid = 1'b1; snpLine = {8'h33, 4'd9};
    @(negedge clk);
    updValid = 1'b0; snpValid = 1'b0;
    check(invReq && invIndex == 4'd9, "R8", {invReq, invIndex}, {1'b1, 4'd9});
    ackInv("R9");
    doSnoop(9, 8'h33, 1'b0, "R8");  // snoop clear won over fill
    doUpdate(1'b1, 9, 8'h33);
    @(negedge clk);
    updValid = 1'b1; updSetValid = 1'b1; updIndex = 4'd9; updTag = 8'h44;
    snpValid = 1'b1; snpLine = {8'h33, 4'd9};  // old tag
    @(negedge clk);
    updValid = 1'b0; snpValid = 1'b0;
    check(!invReq, "R8", invReq, 0);
    doSnoop(9, 8'h44, 1'b1, "R8");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule